// File: doc/BRIEF.md
# ISA Bus 32-Line Parallel I/O Port

This block is a general-purpose I/O peripheral for the 8-bit ISA expansion bus. It provides 32 lines: four byte-wide output registers that the host writes with port-output instructions, and four byte-wide input ports that the host reads with port-input instructions. It watches the address lines, the active-low port-write and port-read strobes, and the DMA address-enable line. It acts only on port I/O cycles that fall in its two 4-byte windows. The output window starts at 0x338 and the input window starts at 0x238.

All bus strobes are brought into a fast local clock through two-flop synchronizers. A port write takes effect once, when the synchronized write strobe is released. It uses the address and data captured while that strobe was low. A port read enables an external tri-state transceiver through `bus_drv_en` and presents the addressed input byte on `bus_rdata`. The input pins are registered once on the local clock. The bus side has no back-pressure: the host's strobe width sets the timing. The host must keep the address and data stable for at least three local clocks after a strobe rises.

Top module: `isa_gpio_port`

## Requirements
- R1: While reset is high and after it falls, before any write, all 32 bits of `gpo` are 0 and `bus_drv_en` is 0.
- R2: A port write to address 0x338+k (k = 0..3) with `aen` low stores the `bus_wdata` byte into bits [8k+7:8k] of `gpo`. The other bytes keep their values.
- R3: An output byte keeps its value through reads, through writes to other registers and through idle cycles, until the next write to its own address.
- R4: A port write while `aen` is high changes no bit of `gpo`.
- R5: Address and data activity in the output window without `iow_n` going low (a memory cycle) changes no bit of `gpo`.
- R6: Port writes to addresses outside 0x338..0x33B change no bit of `gpo`. This includes the input window (0x238) and addresses that differ in any of bits 15..2 (for example 0x33C and 0x738).
- R7: A port read at 0x238+k with `aen` low holds `bus_drv_en` at 1 from the second clock after `ior_n` falls. While it is 1, `bus_rdata` equals bits [8k+7:8k] of `gpi`.
- R8: `bus_drv_en` is 0, and `bus_rdata` is 0, whenever `ior_n` is high, the address is outside 0x238..0x23B (including the output window), or `aen` is high.
- R9: A write does not change `gpo` while `iow_n` is still low. It updates `gpo` exactly once, on the third clock after `iow_n` rises.
- R10: A change on `gpi` during a read appears on `bus_rdata` within two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, much faster than the bus strobes |
| rst | input | 1 | Active-high synchronous reset |
| sa | input | 16 | Bus address lines A15..A0 |
| aen | input | 1 | High while the DMA controller owns the bus |
| iow_n | input | 1 | Active-low port-write strobe |
| ior_n | input | 1 | Active-low port-read strobe |
| bus_wdata | input | 8 | Data bus as seen from the bus (received side of the transceiver) |
| bus_rdata | output | 8 | Byte to be driven onto the data bus during a read |
| bus_drv_en | output | 1 | Enables the tri-state transceiver toward the bus; the bus floats when 0 |
| gpi | input | 32 | Input pins, byte k read at 0x238+k |
| gpo | output | 32 | Output pins, byte k written at 0x338+k |

## Verification
The bound checker watches three things on every cycle. First, `gpo` can only change on the clock that follows a synchronized rise of `iow_n`. Second, the transceiver is never enabled during DMA ownership, outside the input window, or without a read strobe seen two clocks earlier. Third, the read data is zero while the transceiver is off. Only the bench's scenarios can show the rest. That covers the byte placement of each write, values being retained across other traffic, the rejection of memory-style cycles and of neighbouring addresses, and the exact byte returned for each input address under changing pin patterns.

// File: rtl/isa_gpio_pkg.sv
package isa_gpio_pkg;
  // Which port window an address falls into
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_OUT  = 2'd1,
    WIN_IN   = 2'd2
  } win_e;
endpackage

// File: rtl/isa_gpio_sync.sv
// Two-flop synchronizer, one chain per bit, reset to an idle level
module isa_gpio_sync #(
  parameter int W = 2,
  parameter logic IDLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic s1, s2;
      always_ff @(posedge clk) begin
        if (rst) begin
          s1 <= IDLE;
          s2 <= IDLE;
        end else begin
          s1 <= d[i];
          s2 <= s1;
        end
      end
      assign q[i] = s2;
    end
  endgenerate
endmodule

// File: rtl/isa_gpio_decode.sv
// Window decoder: upper address bits pick a window, low bits pick a byte
module isa_gpio_decode
  import isa_gpio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 2,
  parameter logic [ADDR_W-1:0] OUT_BASE = 16'h0338,
  parameter logic [ADDR_W-1:0] IN_BASE  = 16'h0238
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              dma_own,
  output win_e              win,
  output logic [SEL_W-1:0]  sel
);
  localparam int HI_W = ADDR_W - SEL_W;
  localparam logic [HI_W-1:0] OUT_HI = OUT_BASE[ADDR_W-1:SEL_W];
  localparam logic [HI_W-1:0] IN_HI  = IN_BASE[ADDR_W-1:SEL_W];

  logic [HI_W-1:0] hi;
  assign hi  = addr[ADDR_W-1:SEL_W];
  assign sel = addr[SEL_W-1:0];

  always_comb begin
    win = WIN_NONE;
    if (!dma_own) begin
      if (hi == OUT_HI)     win = WIN_OUT;
      else if (hi == IN_HI) win = WIN_IN;
    end
  end
endmodule

// File: rtl/isa_gpio_outregs.sv
// Bank of byte-wide output registers with a single write port
module isa_gpio_outregs #(
  parameter int DATA_W = 8,
  parameter int NPORT  = 4,
  parameter int SEL_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [SEL_W-1:0]        sel,
  input  logic [DATA_W-1:0]       wdata,
  output logic [NPORT*DATA_W-1:0] q
);
  genvar k;
  generate
    for (k = 0; k < NPORT; k++) begin : g_reg
      logic [DATA_W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)                                   r <= '0;
        else if (we && sel == SEL_W'(k))           r <= wdata;
      end
      assign q[k*DATA_W +: DATA_W] = r;
    end
  endgenerate
endmodule

// File: rtl/isa_gpio_port.sv
module isa_gpio_port
  import isa_gpio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NPORT  = 4,
  parameter logic [ADDR_W-1:0] OUT_BASE = 16'h0338,
  parameter logic [ADDR_W-1:0] IN_BASE  = 16'h0238
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       sa,
  input  logic                    aen,
  input  logic                    iow_n,
  input  logic                    ior_n,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  output logic                    bus_drv_en,
  input  logic [NPORT*DATA_W-1:0] gpi,
  output logic [NPORT*DATA_W-1:0] gpo
);
  localparam int SEL_W = (NPORT > 1) ? $clog2(NPORT) : 1;
  localparam int PINS  = NPORT * DATA_W;

  // Strobe synchronization: bit 0 write, bit 1 read
  logic [1:0] strb_s;
  isa_gpio_sync #(.W(2), .IDLE(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ior_n, iow_n}),
    .q   (strb_s)
  );
  logic iow_s, ior_s;
  assign iow_s = strb_s[0];
  assign ior_s = strb_s[1];

  // Write path: hold address/data while strobe low, commit on release
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic              hold_aen;
  logic              iow_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_addr <= '0;
      hold_data <= '0;
      hold_aen  <= 1'b1;
      iow_prev  <= 1'b1;
    end else begin
      iow_prev <= iow_s;
      if (!iow_s) begin
        hold_addr <= sa;
        hold_data <= bus_wdata;
        hold_aen  <= aen;
      end
    end
  end

  win_e             wr_win;
  logic [SEL_W-1:0] wr_sel;
  isa_gpio_decode #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .OUT_BASE(OUT_BASE), .IN_BASE(IN_BASE)
  ) u_dec_wr (
    .addr    (hold_addr),
    .dma_own (hold_aen),
    .win     (wr_win),
    .sel     (wr_sel)
  );

  logic wr_commit;
  assign wr_commit = iow_s && !iow_prev && (wr_win == WIN_OUT);

  isa_gpio_outregs #(.DATA_W(DATA_W), .NPORT(NPORT), .SEL_W(SEL_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_commit),
    .sel   (wr_sel),
    .wdata (hold_data),
    .q     (gpo)
  );

  // Read path: pins registered once, bus enable from live address
  logic [PINS-1:0] gpi_q;
  always_ff @(posedge clk) begin
    if (rst) gpi_q <= '0;
    else     gpi_q <= gpi;
  end

  logic [DATA_W-1:0] in_byte [NPORT];
  genvar k;
  generate
    for (k = 0; k < NPORT; k++) begin : g_in
      assign in_byte[k] = gpi_q[k*DATA_W +: DATA_W];
    end
  endgenerate

  win_e             rd_win;
  logic [SEL_W-1:0] rd_sel;
  isa_gpio_decode #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W), .OUT_BASE(OUT_BASE), .IN_BASE(IN_BASE)
  ) u_dec_rd (
    .addr    (sa),
    .dma_own (aen),
    .win     (rd_win),
    .sel     (rd_sel)
  );

  assign bus_drv_en = !ior_s && (rd_win == WIN_IN);
  assign bus_rdata  = bus_drv_en ? in_byte[rd_sel] : '0;
endmodule

// File: rtl/isa_gpio_port_chk.sv
module isa_gpio_port_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NPORT  = 4,
  parameter logic [ADDR_W-1:0] IN_BASE = 16'h0238
) (
  input logic                    clk,
  input logic                    rst,
  input logic [ADDR_W-1:0]       sa,
  input logic                    aen,
  input logic                    iow_n,
  input logic                    ior_n,
  input logic [DATA_W-1:0]       bus_rdata,
  input logic                    bus_drv_en,
  input logic [NPORT*DATA_W-1:0] gpo
);
  localparam int SEL_W = (NPORT > 1) ? $clog2(NPORT) : 1;

  // Cycles since reset, saturating, so history windows stay inside it
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // R1
  gpo_reset_clear_chk: assert property (@(posedge clk) $fell(rst) |-> (gpo == '0 && !bus_drv_en));

  // R9
  gpo_change_on_release_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd5 && !$stable(gpo)) |-> ($past(iow_n, 3) && !$past(iow_n, 4)));

  // R8
  drv_off_dma_chk: assert property (@(posedge clk) disable iff (rst) aen |-> !bus_drv_en);

  // R8
  drv_window_chk: assert property (@(posedge clk) disable iff (rst)
    bus_drv_en |-> (sa[ADDR_W-1:SEL_W] == IN_BASE[ADDR_W-1:SEL_W]));

  // R7
  drv_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd3 && bus_drv_en) |-> !$past(ior_n, 2));

  // R8
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_drv_en |-> (bus_rdata == '0));
endmodule

bind isa_gpio_port isa_gpio_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPORT(NPORT), .IN_BASE(IN_BASE)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sa         (sa),
  .aen        (aen),
  .iow_n      (iow_n),
  .ior_n      (ior_n),
  .bus_rdata  (bus_rdata),
  .bus_drv_en (bus_drv_en),
  .gpo        (gpo)
);

// File: tb/isa_gpio_port_tb.sv
module isa_gpio_port_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sa = '0;
  logic        aen = 1'b0;
  logic        iow_n = 1'b1;
  logic        ior_n = 1'b1;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_drv_en;
  logic [31:0] gpi = '0;
  logic [31:0] gpo;

  always #5 clk = ~clk;

  isa_gpio_port u_dut (
    .clk(clk), .rst(rst), .sa(sa), .aen(aen), .iow_n(iow_n), .ior_n(ior_n),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_drv_en(bus_drv_en),
    .gpi(gpi), .gpo(gpo)
  );

  // Scoreboard: kind 0 compares gpo, kind 1 compares {drv_en, rdata}
  typedef struct {
    string       req;
    int          kind;
    logic [31:0] val;
  } item_t;

  item_t       sb_q[$];
  event        smp;
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] model_gpo = '0;
  bit          done = 0;

  always @(smp) begin
    item_t it;
    logic [31:0] act;
    while (sb_q.size() > 0) begin
      it  = sb_q.pop_front();
      act = (it.kind == 0) ? gpo : {23'd0, bus_drv_en, bus_rdata};
      n_cmp++;
      if (act !== it.val) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.val);
      end
    end
  end

  task automatic expect_item(input string req, input int kind, input logic [31:0] val);
    item_t it;
    it.req = req; it.kind = kind; it.val = val;
    sb_q.push_back(it);
    -> smp;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Full port write; model updated from the requirement rules
  task automatic io_write(input logic [15:0] a, input logic [7:0] d, input logic dma);
    @(negedge clk);
    sa = a; bus_wdata = d; aen = dma;
    idle(2);
    iow_n = 1'b0;
    idle(4);
    iow_n = 1'b1;
    idle(5);
    sa = 16'h0000; bus_wdata = 8'h00; aen = 1'b0;
    if (!dma && a[15:2] == 14'(16'h0338 >> 2))
      model_gpo[a[1:0]*8 +: 8] = d;
  endtask

  task automatic io_read(input string req, input logic [15:0] a, input logic dma,
                         input logic [8:0] exp);
    @(negedge clk);
    sa = a; aen = dma;
    idle(1);
    ior_n = 1'b0;
    idle(4);
    expect_item(req, 1, {23'd0, exp});
    ior_n = 1'b1;
    idle(3);
    sa = 16'h0000; aen = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(1);
    expect_item("R1 gpo in reset", 0, 32'h0);
    idle(4);
    rst = 1'b0;
    idle(2);
    expect_item("R1 gpo after reset", 0, 32'h0);
    expect_item("R1 drv_en after reset", 1, 32'h0);

    // R2: each byte lands in its own lane
    io_write(16'h0338, 8'h11, 1'b0); expect_item("R2 byte0", 0, model_gpo);
    io_write(16'h0339, 8'h22, 1'b0); expect_item("R2 byte1", 0, model_gpo);
    io_write(16'h033A, 8'h33, 1'b0); expect_item("R2 byte2", 0, model_gpo);
    io_write(16'h033B, 8'h44, 1'b0); expect_item("R2 byte3", 0, model_gpo);

    // R7: reads of each input byte, two patterns
    gpi = 32'hA55A_3CC3;
    for (int k = 0; k < 4; k++)
      io_read("R7 read pattern A", 16'h0238 + 16'(k), 1'b0, {1'b1, gpi[k*8 +: 8]});
    gpi = 32'h0F1E_2D96;
    for (int k = 0; k < 4; k++)
      io_read("R7 read pattern B", 16'h0238 + 16'(k), 1'b0, {1'b1, gpi[k*8 +: 8]});

    // R3: retained after reads and idle, then single lane rewrite
    idle(6);
    expect_item("R3 retained after reads", 0, 32'h4433_2211);
    io_write(16'h033A, 8'hC7, 1'b0);
    expect_item("R3 only byte2 changed", 0, 32'h44C7_2211);

    // R4: DMA-owned write ignored
    io_write(16'h0339, 8'hEE, 1'b1);
    expect_item("R4 aen write ignored", 0, 32'h44C7_2211);

    // R5: address/data activity without port-write strobe
    @(negedge clk);
    sa = 16'h033B; bus_wdata = 8'h99;
    idle(8);
    bus_wdata = 8'h5A;
    idle(8);
    sa = 16'h0000; bus_wdata = 8'h00;
    idle(4);
    expect_item("R5 no strobe no change", 0, 32'h44C7_2211);

    // R6: writes outside the output window
    io_write(16'h0238, 8'hAB, 1'b0);
    expect_item("R6 input window write ignored", 0, 32'h44C7_2211);
    io_write(16'h033C, 8'hAB, 1'b0);
    expect_item("R6 0x33C ignored", 0, 32'h44C7_2211);
    io_write(16'h0738, 8'hAB, 1'b0);
    expect_item("R6 0x738 ignored", 0, 32'h44C7_2211);

    // R8: no drive without strobe, outside window, or under DMA
    @(negedge clk);
    sa = 16'h0238;
    idle(4);
    expect_item("R8 no strobe no drive", 1, 32'h0);
    sa = 16'h0000;
    io_read("R8 output window not driven", 16'h0338, 1'b0, 9'h000);
    io_read("R8 dma read not driven", 16'h023A, 1'b1, 9'h000);

    // R9: no update while strobe low, update on third clock after release
    @(negedge clk);
    sa = 16'h0338; bus_wdata = 8'h6D;
    idle(2);
    iow_n = 1'b0;
    idle(6);
    expect_item("R9 unchanged while strobe low", 0, 32'h44C7_2211);
    iow_n = 1'b1;
    idle(2);
    expect_item("R9 unchanged two clocks after release", 0, 32'h44C7_2211);
    idle(1);
    expect_item("R9 updated third clock", 0, 32'h44C7_226D);
    idle(3);
    sa = 16'h0000; bus_wdata = 8'h00;
    idle(3);
    expect_item("R9 single update", 0, 32'h44C7_226D);

    // R10: pin change during a read follows within two clocks
    @(negedge clk);
    sa = 16'h0239;
    ior_n = 1'b0;
    idle(4);
    expect_item("R10 before pin change", 1, {23'd0, 1'b1, 8'h2D});
    gpi = 32'h0F1E_E196;
    idle(2);
    expect_item("R10 after pin change", 1, {23'd0, 1'b1, 8'hE1});
    ior_n = 1'b1;
    idle(3);
    sa = 16'h0000;
    idle(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule